// File: doc/BRIEF.md
# Two-Machine Dice Game Controller

This block runs a complete dice game from a single roll button. Two dice are modelled as chained modulo-N counters that spin while the player holds the button. They stop at whatever value they hold when the button is released, and that moment is effectively random. The sum of the two faces is scored by a four-state scoring machine. A result that neither wins nor loses becomes the player's point, and the player keeps rolling until the point comes up again (win) or a seven appears (loss).

The button itself is handled by a separate two-state spin sequencer. The scoring machine calls it with an enable and waits for its completion pulse. The same button logic therefore serves both the opening roll and every re-roll without being duplicated. The button and the new-game input are expected to be debounced and synchronous to the clock. The power-on reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `dice_game_ctl`

## Requirements
- R1: After reset both lamps are off, both dice show 1 and the sum output is 2.
- R2: A die face steps 1,2,…,FACES,1 on each clock edge where it advances. The low die advances on every edge where the spin sequencer is rolling. The high die advances only on those edges where the low die shows FACES. The sum output always equals die_a plus die_b.
- R3: While enabled, the spin sequencer needs one clock edge to start after roll_btn goes high, and the dice do not move on that edge. The dice then advance once per edge for as long as roll_btn stays high. Releasing the button produces a single-cycle completion pulse and returns the sequencer to idle.
- R4: On the opening roll a sum of FACES+1 (7) or 2*FACES-1 (11) lights win_lamp on the edge that completes the roll.
- R5: On the opening roll a sum of 2, 3 or 2*FACES (12) lights lose_lamp.
- R6: Any other opening sum is stored as the point, leaves both lamps off and calls for another roll.
- R7: On a re-roll a sum equal to the stored point lights win_lamp.
- R8: On a re-roll a sum of 7 lights lose_lamp.
- R9: On a re-roll any other sum leaves both lamps off, keeps the point and calls for another roll.
- R10: A lit lamp stays lit until new_game is 1 on a clock edge, which returns to the opening-roll state with both lamps off. While a lamp is lit, roll_btn has no effect and the dice hold.
- R11: new_game has no effect while a game is in progress. The lamps stay off and the stored point is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| roll_btn | input | 1 | Debounced roll button, 1 while pressed |
| new_game | input | 1 | Debounced new-game button, 1 while pressed |
| win_lamp | output | 1 | 1 while the game is won |
| lose_lamp | output | 1 | 1 while the game is lost |
| die_a | output | DIE_W (3) | Face of the low die, 1..FACES |
| die_b | output | DIE_W (3) | Face of the high die, 1..FACES |
| dice_sum | output | SUM_W (4) | die_a plus die_b |

## Verification
Several properties are checked on every cycle. Die faces stay inside their range and hold still whenever no roll is active. The low die wraps to 1 after FACES. The completion pulse lasts exactly one cycle, and rolling only happens while the scoring machine grants the enable. The point register changes only on a store, and a lit lamp survives any cycle without new_game. Whether a given sum is scored correctly against the opening rules or against the stored point can only be shown by the bench's scenarios. The bench steers the dice through all 36 face pairs on the opening roll, follows every point game to a match or a seven, and exercises the ignored-button and ignored-new-game cases.

// File: rtl/dice_pkg.sv
package dice_pkg;

  // Scoring machine states; the encoding is fixed.
  typedef enum logic [1:0] {
    GAME_FIRST = 2'b00,
    GAME_AGAIN = 2'b01,
    GAME_WON   = 2'b10,
    GAME_LOST  = 2'b11
  } game_state_e;

  // Spin sequencer states.
  typedef enum logic {
    SPIN_IDLE   = 1'b0,
    SPIN_ACTIVE = 1'b1
  } spin_state_e;

endpackage

// File: rtl/die_pair.sv
module die_pair #(
  parameter int FACES    = 6,
  parameter int NUM_DICE = 2,
  parameter int DIE_W    = $clog2(FACES + 1),
  parameter int SUM_W    = $clog2(2 * FACES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        advance,
  output logic [NUM_DICE-1:0][DIE_W-1:0] face,
  output logic [SUM_W-1:0]            sum
);

  localparam logic [DIE_W-1:0] FACE_ONE = DIE_W'(1);
  localparam logic [DIE_W-1:0] FACE_TOP = DIE_W'(FACES);

  logic [NUM_DICE-1:0] carry;

  for (genvar i = 0; i < NUM_DICE; i++) begin : g_die
    logic [DIE_W-1:0] face_nx;

    if (i == 0) begin : g_first
      assign carry[i] = advance;
    end else begin : g_chain
      assign carry[i] = carry[i-1] && (face[i-1] == FACE_TOP);
    end

    always_comb begin
      face_nx = face[i];
      if (carry[i]) begin
        face_nx = (face[i] == FACE_TOP) ? FACE_ONE : face[i] + FACE_ONE;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        face[i] <= FACE_ONE;
      end else if (carry[i]) begin
        face[i] <= face_nx;
      end
    end

    // R2: faces never leave 1..FACES
    a_r2_face_range: assert property (@(posedge clk) disable iff (!rst_n)
      (face[i] >= FACE_ONE) && (face[i] <= FACE_TOP));
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NUM_DICE; k++) begin
      sum = sum + SUM_W'(face[k]);
    end
  end

  // R2: nothing moves without an advance
  a_r2_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(face));

  // R2: low die wraps back to one
  a_r2_low_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && face[0] == FACE_TOP) |=> (face[0] == FACE_ONE));

endmodule

// File: rtl/spin_ctl.sv
module spin_ctl
  import dice_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic button,
  output logic spinning,
  output logic finished
);

  spin_state_e st_q, st_nx;

  always_comb begin
    st_nx    = st_q;
    spinning = 1'b0;
    finished = 1'b0;
    unique case (st_q)
      SPIN_IDLE: begin
        if (enable && button) st_nx = SPIN_ACTIVE;
      end
      SPIN_ACTIVE: begin
        if (button) begin
          spinning = 1'b1;
        end else begin
          finished = 1'b1;
          st_nx    = SPIN_IDLE;
        end
      end
      default: st_nx = SPIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SPIN_IDLE;
    else        st_q <= st_nx;
  end

  // R3: completion is a single-cycle pulse
  a_r3_finish_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> !finished);

endmodule

// File: rtl/score_ctl.sv
module score_ctl
  import dice_pkg::*;
#(
  parameter int FACES = 6,
  parameter int SUM_W = $clog2(2 * FACES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finished,
  input  logic             new_game,
  input  logic [SUM_W-1:0] sum,
  input  logic [SUM_W-1:0] point,
  output logic             en_roll,
  output logic             store_point,
  output logic             win_lamp,
  output logic             lose_lamp
);

  localparam logic [SUM_W-1:0] SUM_SEVEN  = SUM_W'(FACES + 1);
  localparam logic [SUM_W-1:0] SUM_ELEVEN = SUM_W'(2 * FACES - 1);
  localparam logic [SUM_W-1:0] SUM_TWO    = SUM_W'(2);
  localparam logic [SUM_W-1:0] SUM_THREE  = SUM_W'(3);
  localparam logic [SUM_W-1:0] SUM_TOP    = SUM_W'(2 * FACES);

  game_state_e st_q, st_nx;
  logic        natural_win, craps_loss, seven, matched;

  assign natural_win = (sum == SUM_SEVEN) || (sum == SUM_ELEVEN);
  assign craps_loss  = (sum == SUM_TWO) || (sum == SUM_THREE) || (sum == SUM_TOP);
  assign seven       = (sum == SUM_SEVEN);
  assign matched     = (sum == point);

  always_comb begin
    st_nx       = st_q;
    en_roll     = 1'b0;
    store_point = 1'b0;
    unique case (st_q)
      GAME_FIRST: begin
        en_roll = 1'b1;
        if (finished) begin
          if (natural_win)     st_nx = GAME_WON;
          else if (craps_loss) st_nx = GAME_LOST;
          else begin
            store_point = 1'b1;
            st_nx       = GAME_AGAIN;
          end
        end
      end
      GAME_AGAIN: begin
        en_roll = 1'b1;
        if (finished) begin
          if (matched)    st_nx = GAME_WON;
          else if (seven) st_nx = GAME_LOST;
        end
      end
      GAME_WON:  if (new_game) st_nx = GAME_FIRST;
      GAME_LOST: if (new_game) st_nx = GAME_FIRST;
      default:   st_nx = GAME_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GAME_FIRST;
    else        st_q <= st_nx;
  end

  assign win_lamp  = (st_q == GAME_WON);
  assign lose_lamp = (st_q == GAME_LOST);

  // R10: a lit lamp survives any cycle without new_game
  a_r10_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_lamp && !new_game) |=> win_lamp);
  a_r10_lose_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lose_lamp && !new_game) |=> lose_lamp);

  // R4: an opening seven wins on the completing edge
  a_r4_opening_seven: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GAME_FIRST && finished && seven) |=> win_lamp);

  // R7: matching the point wins
  a_r7_point_match: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GAME_AGAIN && finished && matched) |=> win_lamp);

endmodule

// File: rtl/dice_game_ctl.sv
module dice_game_ctl #(
  parameter int  FACES = 6,
  localparam int DIE_W = $clog2(FACES + 1),
  localparam int SUM_W = $clog2(2 * FACES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             roll_btn,
  input  logic             new_game,
  output logic             win_lamp,
  output logic             lose_lamp,
  output logic [DIE_W-1:0] die_a,
  output logic [DIE_W-1:0] die_b,
  output logic [SUM_W-1:0] dice_sum
);

  logic [1:0]             rst_pipe;
  logic                   rst_core_n;
  logic                   en_roll, spinning, finished, store_point;
  logic [SUM_W-1:0]       point_q;
  logic [1:0][DIE_W-1:0]  faces;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  spin_ctl i_spin (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .enable   (en_roll),
    .button   (roll_btn),
    .spinning (spinning),
    .finished (finished)
  );

  die_pair #(
    .FACES    (FACES),
    .NUM_DICE (2),
    .DIE_W    (DIE_W),
    .SUM_W    (SUM_W)
  ) i_dice (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .advance (spinning),
    .face    (faces),
    .sum     (dice_sum)
  );

  score_ctl #(
    .FACES (FACES),
    .SUM_W (SUM_W)
  ) i_score (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .finished    (finished),
    .new_game    (new_game),
    .sum         (dice_sum),
    .point       (point_q),
    .en_roll     (en_roll),
    .store_point (store_point),
    .win_lamp    (win_lamp),
    .lose_lamp   (lose_lamp)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)      point_q <= '0;
    else if (store_point) point_q <= dice_sum;
  end

  assign die_a = faces[0];
  assign die_b = faces[1];

  // R3: the dice only spin while the scoring machine grants a roll
  a_r3_spin_granted: assert property (@(posedge clk) disable iff (!rst_core_n)
    spinning |-> en_roll);

  // R6: point only changes on a store
  a_r6_point_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !store_point |=> $stable(point_q));

endmodule

// File: tb/test_dice_game_ctl.sv
module test_dice_game_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       roll_btn = 1'b0;
  logic       new_game = 1'b0;
  logic       win_lamp, lose_lamp;
  logic [2:0] die_a, die_b;
  logic [3:0] dice_sum;

  int checks = 0;
  int fails  = 0;
  int pos    = 0;   // dice position 0..35, low die is the fast digit

  always #10 clk = ~clk;

  dice_game_ctl i_dice_game_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .roll_btn  (roll_btn),
    .new_game  (new_game),
    .win_lamp  (win_lamp),
    .lose_lamp (lose_lamp),
    .die_a     (die_a),
    .die_b     (die_b),
    .dice_sum  (dice_sum)
  );

  function automatic int lo_at(int p);  return p % 6 + 1;        endfunction
  function automatic int hi_at(int p);  return (p / 6) % 6 + 1;  endfunction
  function automatic int sum_at(int p); return lo_at(p) + hi_at(p); endfunction

  function automatic int pos_with_sum(int s);
    for (int q = 0; q < 36; q++) if (sum_at(q) == s) return q;
    return 0;
  endfunction

  function automatic int pos_neutral(int pnt);
    for (int q = 0; q < 36; q++) if (sum_at(q) != 7 && sum_at(q) != pnt) return q;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_dice(string req);
    chk({req, " die_a"}, int'(die_a), lo_at(pos));
    chk({req, " die_b"}, int'(die_b), hi_at(pos));
    chk({req, " sum"}, int'(dice_sum), sum_at(pos));
  endtask

  task automatic chk_lamps(string req, int w, int l);
    chk({req, " win"}, int'(win_lamp), w);
    chk({req, " lose"}, int'(lose_lamp), l);
  endtask

  // Press, hold long enough to reach target, release; ends on a negedge.
  task automatic roll_to(int target);
    int d;
    d = (target - pos + 36) % 36;
    roll_btn = 1'b1;
    @(negedge clk);
    chk_dice("R3 start edge");
    repeat (d) @(negedge clk);
    roll_btn = 1'b0;
    @(negedge clk);
    pos = target;
    chk_dice("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_lamps("R1", 0, 0);
    chk_dice("R1");

    for (int p = 0; p < 36; p++) begin
      int s;
      s = sum_at(p);
      roll_to(p);
      if (s == 7 || s == 11) begin
        chk_lamps("R4", 1, 0);
      end else if (s == 2 || s == 3 || s == 12) begin
        chk_lamps("R5", 0, 1);
      end else begin
        chk_lamps("R6", 0, 0);
        roll_to(pos_neutral(s));
        chk_lamps("R9", 0, 0);
        if (p % 3 == 0) begin
          new_game = 1'b1;
          @(negedge clk);
          new_game = 1'b0;
          @(negedge clk);
          chk_lamps("R11", 0, 0);
        end
        if (p % 2 == 0) begin
          roll_to(pos_with_sum(s));
          chk_lamps("R7", 1, 0);
        end else begin
          roll_to(pos_with_sum(7));
          chk_lamps("R8", 0, 1);
        end
      end

      // Lamp holds and the button is ignored while the game is over
      if (p % 2 == 0) begin
        int w, l;
        w = int'(win_lamp);
        l = int'(lose_lamp);
        roll_btn = 1'b1;
        repeat (5) @(negedge clk);
        roll_btn = 1'b0;
        @(negedge clk);
        chk_dice("R10 frozen");
        chk_lamps("R10 held", w, l);
      end
      new_game = 1'b1;
      @(negedge clk);
      new_game = 1'b0;
      @(negedge clk);
      chk_lamps("R10 cleared", 0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule